// File: doc/BRIEF.md
# Tightly Coupled Memory Window Decoder

This block holds the configuration of one tightly coupled memory window and decides, every cycle, whether an incoming 32-bit address lands inside it. The configuration is a single 32-bit register with three live fields:

- a base address in the upper twenty bits;
- a read-only size code;
- an enable bit.

Software reaches the register over a small register bus that carries a privilege flag. Only privileged accesses are honoured. Any other access is refused and is reported by a one-cycle error pulse.

The window size is fixed when the block is built, through the parameter `MEM_KB`, given in kilobytes. Base bits that fall inside the window size have no meaning, so the block discards them. They read back as zero and take no part in the address match. After reset, the base and the enable bit come from two strap inputs. One strap selects between a zero base and a build-time base value. The other strap gives the initial enable.

Top module: `tcm_window_decoder`

## Requirements
- R1: The readback word places the base in bits [31:12], the size code in bits [6:2] and the enable in bit 0. Bits [11:7] and bit 1 always read as zero.
- R2: The size code is read-only. With `MEM_KB` = 0 the code is 0. Otherwise the code is log2(`MEM_KB`)+1, so 4 KB gives 3, 64 KB gives 7 and 8 MB gives 14. A write never changes the code.
- R3: Base bits [log2(window bytes)-1:12] are dropped on write and on reset. They read back as zero and are ignored in hit decoding.
- R4: While `rst` is high, the base loads zero if `strap_loc` is 0. If `strap_loc` is 1, it loads `IMPL_BASE`[31:12] with the R3 masking applied.
- R5: While `rst` is high, the enable bit loads the value of `strap_en`.
- R6: A privileged write (`reg_sel`=1, `reg_wr`=1, `reg_priv`=1) updates base and enable at the next clock edge. Readback and hit decoding use the new values from the following cycle.
- R7: A non-privileged write leaves the register unchanged. A non-privileged read returns zero on `reg_rdata`. `reg_rdata` shows the register only during a privileged read (`reg_sel`=1, `reg_wr`=0, `reg_priv`=1), and is zero otherwise.
- R8: `acc_err` is high in the cycle after each cycle with `reg_sel`=1 and `reg_priv`=0, and low after any other cycle.
- R9: `hit` is combinational. It is 1 when enable is 1, the size is non-zero and `addr`[31:W] equals base bits [31:W], where W = log2(window bytes).
- R10: `hit` is 0 whenever the enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_loc | input | 1 | Selects the reset base: 0 for zero, 1 for the build-time value |
| strap_en | input | 1 | Reset value of the enable bit |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 for a write, 0 for a read |
| reg_priv | input | 1 | Access is privileged |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| acc_err | output | 1 | One-cycle pulse after a refused access |
| addr | input | 32 | Address to decode |
| hit | output | 1 | Address falls inside the enabled window |

## Verification
The assertions assume that the bus inputs and `addr` are stable around each rising edge. They also assume that `rst` is high at the first edge, so the reset check on the enable bit has a defined past value. The bench changes every input one time unit after a rising edge and samples at the falling edge. It holds reset for several cycles before any access. Reserved write bits are set in one write to show that they are dropped. Strap values change only while reset is asserted.

// File: rtl/tcmwin_pkg.sv
`timescale 1ns/1ps
package tcmwin_pkg;

    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned BASE_LO = 12;
    localparam int unsigned BASE_W  = ADDR_W - BASE_LO;
    localparam int unsigned CODE_W  = 5;
    localparam int unsigned CODE_LO = 2;
    localparam int unsigned EN_POS  = 0;

    typedef logic [BASE_W-1:0] base_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [ADDR_W-1:0] word_t;

    // Stored window state
    typedef struct packed {
        base_t base;
        logic  en;
    } win_state_t;

    // Bus access qualification
    typedef struct packed {
        logic wr_ok;
        logic rd_ok;
        logic refused;
    } grant_t;

    // Supported sizes: zero, or a power of two from 4 KB to 8 MB
    function automatic bit kb_ok(input int unsigned kb);
        if (kb == 0) return 1'b1;
        return (kb >= 4) && (kb <= 8192) && ((kb & (kb - 1)) == 0);
    endfunction

    function automatic code_t size_code(input int unsigned kb);
        if (kb == 0) return '0;
        return code_t'($clog2(kb) + 1);
    endfunction

    // Number of address bits spanned by the window
    function automatic int unsigned win_bits(input int unsigned kb);
        if (kb == 0) return BASE_LO;
        return $clog2(kb) + 10;
    endfunction

    // Base bits that survive masking (those at or above the window span)
    function automatic base_t keep_mask(input int unsigned kb);
        base_t m;
        for (int unsigned i = 0; i < BASE_W; i++) begin
            m[i] = ((i + BASE_LO) >= win_bits(kb));
        end
        return m;
    endfunction

    function automatic word_t pack_image(input win_state_t s, input code_t c);
        word_t img;
        img                          = '0;
        img[ADDR_W-1:BASE_LO]        = s.base;
        img[CODE_LO+CODE_W-1:CODE_LO] = c;
        img[EN_POS]                  = s.en;
        return img;
    endfunction

endpackage

// File: rtl/tcmwin_access.sv
`timescale 1ns/1ps
module tcmwin_access
    import tcmwin_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sel,
    input  logic   wr,
    input  logic   priv,
    output grant_t grant,
    output logic   acc_err
);

    always_comb begin
        grant.wr_ok   = sel && wr && priv;
        grant.rd_ok   = sel && !wr && priv;
        grant.refused = sel && !priv;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_err <= 1'b0;
        end else begin
            acc_err <= grant.refused;
        end
    end

    // R8
    refused_err_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && !priv) |=> acc_err);

    // R8
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !(sel && !priv) |=> !acc_err);

endmodule

// File: rtl/tcmwin_cfg.sv
`timescale 1ns/1ps
module tcmwin_cfg
    import tcmwin_pkg::*;
#(
    parameter int unsigned MEM_KB    = 64,
    parameter logic [31:0] IMPL_BASE = 32'h0012_3000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       strap_loc,
    input  logic       strap_en,
    input  logic       wr_ok,
    input  base_t      wr_base,
    input  logic       wr_en,
    output win_state_t st
);

    localparam base_t KEEP     = keep_mask(MEM_KB);
    localparam base_t RST_BASE = base_t'(IMPL_BASE >> BASE_LO) & KEEP;

    always_ff @(posedge clk) begin
        if (rst) begin
            st.base <= strap_loc ? RST_BASE : '0;
            st.en   <= strap_en;
        end else if (wr_ok) begin
            st.base <= wr_base & KEEP;
            st.en   <= wr_en;
        end
    end

    // R6
    store_en_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ok |=> (st.en == $past(wr_en)));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_ok |=> $stable(st));

endmodule

// File: rtl/tcmwin_match.sv
`timescale 1ns/1ps
module tcmwin_match
    import tcmwin_pkg::*;
#(
    parameter int unsigned MEM_KB = 64
) (
    input  logic  en,
    input  base_t base,
    input  base_t addr_hi,
    output logic  hit
);

    localparam base_t KEEP = keep_mask(MEM_KB);

    generate
        if (MEM_KB == 0) begin : g_empty
            assign hit = 1'b0;
        end else begin : g_cmp
            base_t diff;
            always_comb begin
                diff = (addr_hi ^ base) & KEEP;
                hit  = en && (diff == '0);
            end
        end
    endgenerate

endmodule

// File: rtl/tcm_window_decoder.sv
`timescale 1ns/1ps
module tcm_window_decoder
    import tcmwin_pkg::*;
#(
    parameter int unsigned MEM_KB    = 64,
    parameter logic [31:0] IMPL_BASE = 32'h0012_3000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        strap_loc,
    input  logic        strap_en,
    input  logic        reg_sel,
    input  logic        reg_wr,
    input  logic        reg_priv,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        acc_err,
    input  logic [31:0] addr,
    output logic        hit
);

    localparam code_t SIZE_CODE = size_code(MEM_KB);
    localparam base_t KEEP      = keep_mask(MEM_KB);
    localparam word_t WR_MASK   = {KEEP, {BASE_LO{1'b0}}} | word_t'(1);
    localparam word_t CODE_WORD = word_t'(SIZE_CODE) << CODE_LO;

    generate
        if (!kb_ok(MEM_KB)) begin : g_bad_size
            $error("tcm_window_decoder: MEM_KB=%0d is not a supported window size", MEM_KB);
        end
    endgenerate

    grant_t     grant;
    win_state_t st;
    word_t      image;

    tcmwin_access u_access (
        .clk     (clk),
        .rst     (rst),
        .sel     (reg_sel),
        .wr      (reg_wr),
        .priv    (reg_priv),
        .grant   (grant),
        .acc_err (acc_err)
    );

    tcmwin_cfg #(
        .MEM_KB    (MEM_KB),
        .IMPL_BASE (IMPL_BASE)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .strap_loc (strap_loc),
        .strap_en  (strap_en),
        .wr_ok     (grant.wr_ok),
        .wr_base   (reg_wdata[ADDR_W-1:BASE_LO]),
        .wr_en     (reg_wdata[EN_POS]),
        .st        (st)
    );

    tcmwin_match #(
        .MEM_KB (MEM_KB)
    ) u_match (
        .en      (st.en),
        .base    (st.base),
        .addr_hi (addr[ADDR_W-1:BASE_LO]),
        .hit     (hit)
    );

    always_comb begin
        image     = pack_image(st, SIZE_CODE);
        reg_rdata = grant.rd_ok ? image : '0;
    end

    // R2
    wr_readback_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel && reg_wr && reg_priv) |=> (image == (($past(reg_wdata) & WR_MASK) | CODE_WORD)));

    // R7
    refused_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel && reg_wr && !reg_priv) |=> $stable(st));

    // R7
    refused_read_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel && !reg_priv) |-> (reg_rdata == '0));

    // R5
    reset_en_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (st.en == $past(strap_en)));

    // R10
    hit_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> st.en);

    // R9
    hit_match_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> ((((addr ^ image) >> BASE_LO) & word_t'(KEEP)) == '0));

endmodule

// File: tb/sim_tcm_window_decoder.sv
`timescale 1ns/1ps
module sim_tcm_window_decoder;

    typedef enum {F_RD, F_HIT, F_ERR} fld_e;
    typedef struct {
        int          due;
        fld_e        f;
        logic [31:0] exp;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_loc = 1'b0;
    logic        strap_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_priv = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        acc_err;
    logic [31:0] addr = '0;
    logic        hit;

    item_t q[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    tcm_window_decoder u0 (
        .clk       (clk),
        .rst       (rst),
        .strap_loc (strap_loc),
        .strap_en  (strap_en),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_priv  (reg_priv),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .acc_err   (acc_err),
        .addr      (addr),
        .hit       (hit)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc++;

    // Monitor: pops due items at the falling edge and compares
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.f)
                F_RD:    act = reg_rdata;
                F_HIT:   act = {31'b0, hit};
                default: act = {31'b0, acc_err};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s field=%s actual=%h expected=%h", it.req, it.f.name(), act, it.exp);
            end
        end
    end

    task automatic drive(input logic s, input logic w, input logic p,
                         input logic [31:0] d, input logic [31:0] a);
        @(posedge clk);
        #1;
        reg_sel = s; reg_wr = w; reg_priv = p; reg_wdata = d; addr = a;
    endtask

    task automatic want_now(input fld_e f, input logic [31:0] e, input string r);
        q.push_back('{cyc, f, e, r});
    endtask

    task automatic want_next(input fld_e f, input logic [31:0] e, input string r);
        q.push_back('{cyc + 1, f, e, r});
    endtask

    task automatic do_reset(input logic loc, input logic en);
        @(posedge clk);
        #1;
        rst = 1'b1; strap_loc = loc; strap_en = en;
        reg_sel = 1'b0; reg_wr = 1'b0; reg_priv = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    // Size code for 64 KB is 7, so bits [6:2] read as 0x1C; window spans 16 address bits
    initial begin
        do_reset(1'b0, 1'b0);

        // Reset state: zero base, disabled
        drive(1, 0, 1, 32'h0, 32'h0);
        want_now(F_RD, 32'h0000_001C, "R1 R4 R5 reset readback");
        want_now(F_HIT, 32'h0, "R10 disabled after reset");

        // Privileged write with reserved and size bits set
        drive(1, 1, 1, 32'hABCD_FFFF, 32'hABCD_1234);
        want_now(F_HIT, 32'h0, "R6 old state in write cycle");
        want_now(F_RD, 32'h0, "R7 no readback during write");
        want_next(F_ERR, 32'h0, "R8 no error on privileged access");

        drive(1, 0, 1, 32'h0, 32'hABCD_FFFC);
        want_now(F_RD, 32'hABCD_001D, "R2 R3 R6 write readback");
        want_now(F_HIT, 32'h1, "R6 R9 hit top of window");

        drive(0, 0, 0, 32'h0, 32'hABCE_0000);
        want_now(F_HIT, 32'h0, "R9 above window");
        want_now(F_RD, 32'h0, "R7 idle readback zero");
        drive(0, 0, 0, 32'h0, 32'hABCC_FFFF);
        want_now(F_HIT, 32'h0, "R9 below window");
        drive(0, 0, 0, 32'h0, 32'hABCD_0000);
        want_now(F_HIT, 32'h1, "R3 low base bits ignored in hit");

        // Non-privileged read
        drive(1, 0, 0, 32'h0, 32'hABCD_0000);
        want_now(F_RD, 32'h0, "R7 refused read");
        want_next(F_ERR, 32'h1, "R8 error after refused read");

        // Non-privileged write
        drive(1, 1, 0, 32'h0, 32'hABCD_0000);
        want_next(F_ERR, 32'h1, "R8 error after refused write");

        drive(1, 0, 1, 32'h0, 32'hABCD_0000);
        want_now(F_RD, 32'hABCD_001D, "R7 refused write ignored");
        want_now(F_HIT, 32'h1, "R7 window unchanged");
        want_next(F_ERR, 32'h0, "R8 pulse ends");

        // Write a new base with enable off
        drive(1, 1, 1, 32'h1234_5000, 32'h0);
        drive(1, 0, 1, 32'h0, 32'h1234_0000);
        want_now(F_RD, 32'h1234_001C, "R3 masked base, disabled");
        want_now(F_HIT, 32'h0, "R10 disabled no hit");

        // Enable it
        drive(1, 1, 1, 32'h1234_0001, 32'h1234_8000);
        drive(0, 0, 0, 32'h0, 32'h1234_8000);
        want_now(F_HIT, 32'h1, "R6 R9 hit with new base");
        drive(1, 0, 1, 32'h0, 32'h1235_8000);
        want_now(F_RD, 32'h1234_001D, "R1 enabled readback");
        want_now(F_HIT, 32'h0, "R9 miss on next window");

        // Reset with straps high: base 0x00123 masked to 0x00120, enabled
        do_reset(1'b1, 1'b1);
        drive(1, 0, 1, 32'h0, 32'h0012_F000);
        want_now(F_RD, 32'h0012_001D, "R4 R5 strap reset readback");
        want_now(F_HIT, 32'h1, "R4 R9 hit at strap base");
        drive(0, 0, 0, 32'h0, 32'h0013_0000);
        want_now(F_HIT, 32'h0, "R9 miss above strap window");

        drive(0, 0, 0, 32'h0, 32'h0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements) actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule